// File: doc/BRIEF.md
# Double-Buffered Blitter and Scanout

This block is a two-bank frame store shared by a pixel writer (the blitter) and a raster reader (the scanout). The scanout streams the front bank to a display, one pixel for each pixel-clock enable, in line-major order. The blitter fills the back bank with runs of pixels at consecutive addresses. Because the blitter only ever touches the bank that is not on screen, no blit can tear the visible picture.

A control agent drives the blitter over two rendezvous channels. Before each operation the agent sends a one-bit end-of-frame token. A false token is followed by one command word and then a stream of pixels. A true token hands the finished bank to the scanout. The blitter then stalls until the scanout completes its current frame. At that frame boundary the two banks exchange roles. At the top of every frame the scanout offers a start-of-frame rendezvous that the agent must take before any pixel is shown. This lets the agent pace its frame work to the display.

The frame is `H_PIX` pixels wide and `V_LINES` lines tall. Each bank holds `FRAME = H_PIX*V_LINES` pixels of `PIX_W` bits. Pixel n of a frame lives at address n, where n = line*H_PIX + column.

Top module: `dbuf_blit_scan`

## Requirements
- R1: After reset the following hold: `front_bank`=0, `eof_ready`=1, `cp_ready`=0, `sof_valid`=1, `pix_valid`=0 and `line_start`=0.
- R2: A token accepted with `eof_flag`=0 makes the blitter accept exactly one command word next. In that word, `cp_data[ADDR_W-1:0]` is the start address and `cp_data[ADDR_W+CNT_W-1:ADDR_W]` is the pixel count. `eof_ready` stays low until that command and all of its pixels have been taken, and `eof_ready` and `cp_ready` are never high together.
- R3: Each pixel word after a command carries its pixel in `cp_data[PIX_W-1:0]`. Successive pixels go to successive addresses of the back bank, and the address wraps from FRAME-1 to 0.
- R4: A command with a count of 0 takes no pixels, and the blitter is ready for a new token in the next cycle.
- R5: A token accepted with `eof_flag`=1 holds `eof_ready` and `cp_ready` low until the scanout emits the last pixel of a frame. At that edge `front_bank` toggles and `eof_ready` returns high.
- R6: Blits never change the bank being displayed. A frame shown while blits are in progress equals the previous frame.
- R7: At the top of each frame `sof_valid` is high and stays high until `sof_ready` is seen. Any `pix_tick` before that rendezvous produces no pixel.
- R8: After the start-of-frame rendezvous, every `pix_tick` gives one cycle of `pix_valid` on the following cycle. In that cycle `pix_out` is the front-bank pixel at the next raster address, starting from address 0.
- R9: `line_start` is high together with `pix_valid` exactly for pixels whose column is 0.
- R10: When a frame ends with no handoff pending, `front_bank` is unchanged and the same bank is shown again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eof_valid | input | 1 | Agent offers an end-of-frame token |
| eof_flag | input | 1 | Token value: 1 = hand off frame, 0 = a blit follows |
| eof_ready | output | 1 | Blitter waits for a token |
| cp_valid | input | 1 | Agent offers a command or pixel word |
| cp_data | input | CP_W | Command word (start address, count) or pixel |
| cp_ready | output | 1 | Blitter waits for a command or pixel word |
| sof_valid | output | 1 | Scanout offers start-of-frame |
| sof_ready | input | 1 | Agent takes start-of-frame |
| pix_tick | input | 1 | Pixel-clock enable |
| pix_out | output | PIX_W | Displayed pixel |
| pix_valid | output | 1 | `pix_out` carries a pixel this cycle |
| line_start | output | 1 | Current pixel opens a line |
| front_bank | output | 1 | Bank now being displayed |

## Verification
The checker watches the channel discipline on every cycle. It covers the exclusive readiness of the two blitter channels, the start-of-frame offer holding until taken, the requirement that each pixel follows a tick, and the requirement that `line_start` only accompanies a pixel. It also checks that a bank swap happens only out of the stalled handoff state and reopens the token channel. Pixel contents cannot be covered by any per-cycle property, so only the bench scenarios show them: consecutive-address writes with wraparound, zero-length commands, the unchanged display while blits run, redisplay without a handoff, and the new bank appearing only after the frame that follows the handoff.

// File: rtl/dbuf_blit_scan.sv
module dbuf_blit_scan #(
  parameter int H_PIX   = 8,
  parameter int V_LINES = 4,
  parameter int PIX_W   = 8,
  localparam int FRAME  = H_PIX * V_LINES,
  localparam int ADDR_W = $clog2(FRAME),
  localparam int CNT_W  = $clog2(FRAME + 1),
  localparam int CP_W   = (PIX_W > ADDR_W + CNT_W) ? PIX_W : ADDR_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eof_valid,
  input  logic             eof_flag,
  output logic             eof_ready,
  input  logic             cp_valid,
  input  logic [CP_W-1:0]  cp_data,
  output logic             cp_ready,
  output logic             sof_valid,
  input  logic             sof_ready,
  input  logic             pix_tick,
  output logic [PIX_W-1:0] pix_out,
  output logic             pix_valid,
  output logic             line_start,
  output logic             front_bank
);
  localparam int XW    = (H_PIX > 1) ? $clog2(H_PIX) : 1;
  localparam int IDX_W = $clog2(2 * FRAME);

  typedef enum logic [1:0] {B_FLAG, B_CMD, B_PIX, B_WAIT} bst_t;

  bst_t              bst;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [CNT_W-1:0]  wcnt;
  logic [XW-1:0]     xcnt;
  logic              s_run;
  logic [PIX_W-1:0]  mem [2*FRAME];

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a);
    return (a == ADDR_W'(FRAME - 1)) ? '0 : a + 1'b1;
  endfunction

  assign eof_ready = (bst == B_FLAG);
  assign cp_ready  = (bst == B_CMD) || (bst == B_PIX);
  assign sof_valid = !s_run;

  wire               px_go   = s_run && pix_tick;
  wire               last_px = px_go && (raddr == ADDR_W'(FRAME - 1));
  wire               swap    = last_px && (bst == B_WAIT);
  wire               wr_en   = (bst == B_PIX) && cp_valid;
  wire [ADDR_W-1:0]  c_addr  = cp_data[ADDR_W-1:0];
  wire [CNT_W-1:0]   c_cnt   = cp_data[ADDR_W+CNT_W-1:ADDR_W];
  wire [IDX_W-1:0]   wr_idx  = front_bank ? IDX_W'(waddr) : IDX_W'(FRAME) + IDX_W'(waddr);
  wire [IDX_W-1:0]   rd_idx  = front_bank ? IDX_W'(FRAME) + IDX_W'(raddr) : IDX_W'(raddr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bst   <= B_FLAG;
      waddr <= '0;
      wcnt  <= '0;
    end else begin
      case (bst)
        B_FLAG: if (eof_valid) bst <= eof_flag ? B_WAIT : B_CMD;
        B_CMD: if (cp_valid) begin
          waddr <= c_addr;
          wcnt  <= c_cnt;
          bst   <= (c_cnt == '0) ? B_FLAG : B_PIX;
        end
        B_PIX: if (cp_valid) begin
          waddr <= step(waddr);
          wcnt  <= wcnt - 1'b1;
          if (wcnt == CNT_W'(1)) bst <= B_FLAG;
        end
        B_WAIT: if (swap) bst <= B_FLAG;
        default: bst <= B_FLAG;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_run      <= 1'b0;
      raddr      <= '0;
      xcnt       <= '0;
      front_bank <= 1'b0;
      pix_valid  <= 1'b0;
      line_start <= 1'b0;
    end else begin
      pix_valid  <= px_go;
      line_start <= px_go && (xcnt == '0);
      if (swap) front_bank <= ~front_bank;
      if (!s_run) begin
        if (sof_ready) begin
          s_run <= 1'b1;
          raddr <= '0;
          xcnt  <= '0;
        end
      end else if (pix_tick) begin
        raddr <= step(raddr);
        xcnt  <= (xcnt == XW'(H_PIX - 1)) ? '0 : xcnt + 1'b1;
        if (last_px) s_run <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= cp_data[PIX_W-1:0];
    if (px_go) pix_out <= mem[rd_idx];
  end
endmodule

// File: rtl/dbuf_blit_scan_chk.sv
module dbuf_blit_scan_chk (
  input logic clk,
  input logic rst_n,
  input logic eof_ready,
  input logic cp_ready,
  input logic sof_valid,
  input logic sof_ready,
  input logic pix_tick,
  input logic pix_valid,
  input logic line_start,
  input logic front_bank
);
  // R2
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(eof_ready && cp_ready));

  // R5
  swap_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(front_bank) |-> ($past(!eof_ready && !cp_ready) && eof_ready));

  // R10
  swap_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(front_bank) |-> $rose(sof_valid));

  // R7
  sof_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_valid && !sof_ready) |=> sof_valid);

  // R8
  pix_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(pix_tick && !sof_valid));

  // R9
  line_start_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> pix_valid);
endmodule

bind dbuf_blit_scan dbuf_blit_scan_chk i_chk (
  .clk(clk), .rst_n(rst_n), .eof_ready(eof_ready), .cp_ready(cp_ready),
  .sof_valid(sof_valid), .sof_ready(sof_ready), .pix_tick(pix_tick),
  .pix_valid(pix_valid), .line_start(line_start), .front_bank(front_bank)
);

// File: tb/test_dbuf_blit_scan.sv
module test_dbuf_blit_scan;
  localparam int H = 8, V = 4, PW = 8;
  localparam int FR = H * V, AW = 5, CW = 6, CPW = 11;
  // stimulus: start address, count, seed; expected bank contents follow from the model
  localparam int BLITS [5][3] = '{'{0, 32, 16}, '{3, 5, 128}, '{7, 0, 99},
                                  '{30, 4, 192}, '{12, 1, 250}};

  logic clk = 0, rst_n = 0;
  logic eof_valid = 0, eof_flag = 0, cp_valid = 0, sof_ready = 0, pix_tick = 0;
  logic [CPW-1:0] cp_data = '0;
  logic eof_ready, cp_ready, sof_valid, pix_valid, line_start, front_bank;
  logic [PW-1:0] pix_out;
  int n_chk = 0, n_bad = 0;
  int model [2][FR];
  bit done = 0;

  always #10 clk = ~clk;

  dbuf_blit_scan #(.H_PIX(H), .V_LINES(V), .PIX_W(PW)) i_dbuf_blit_scan (
    .clk(clk), .rst_n(rst_n), .eof_valid(eof_valid), .eof_flag(eof_flag),
    .eof_ready(eof_ready), .cp_valid(cp_valid), .cp_data(cp_data),
    .cp_ready(cp_ready), .sof_valid(sof_valid), .sof_ready(sof_ready),
    .pix_tick(pix_tick), .pix_out(pix_out), .pix_valid(pix_valid),
    .line_start(line_start), .front_bank(front_bank));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_eof(input bit flag);
    eof_valid = 1; eof_flag = flag;
    while (!eof_ready) @(negedge clk);
    @(negedge clk);
    eof_valid = 0;
  endtask

  task automatic send_cp(input int word);
    cp_valid = 1; cp_data = CPW'(word);
    while (!cp_ready) @(negedge clk);
    @(negedge clk);
    cp_valid = 0;
  endtask

  task automatic blit(input int bank, input int start, input int cnt, input int seed);
    int a;
    send_eof(0);
    send_cp((cnt << AW) | start);
    a = start;
    for (int k = 0; k < cnt; k++) begin
      if (k == 1) check(eof_ready == 0, "R2 token held during pixels", eof_ready, 0);
      send_cp((seed + k) & 8'hFF);
      model[bank][a] = (seed + k) & 8'hFF;
      a = (a + 1) % FR;
    end
  endtask

  task automatic take_frame(input int bank, input bit chk_val, input string req);
    sof_ready = 1;
    while (!sof_valid) @(negedge clk);
    @(negedge clk);
    sof_ready = 0;
    for (int p = 0; p < FR; p++) begin
      pix_tick = 1;
      @(negedge clk);
      pix_tick = 0;
      check(pix_valid == 1, "R8 pixel valid after tick", pix_valid, 1);
      check(line_start == (p % H == 0), "R9 line start", line_start, p % H == 0);
      if (chk_val) check(pix_out == model[bank][p], req, pix_out, model[bank][p]);
      if (p % 5 == 4) begin
        @(negedge clk);
        check(pix_valid == 0, "R8 no pixel without tick", pix_valid, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(front_bank == 0, "R1 front_bank", front_bank, 0);
    check(eof_ready == 1, "R1 eof_ready", eof_ready, 1);
    check(cp_ready == 0, "R1 cp_ready", cp_ready, 0);
    check(sof_valid == 1, "R1 sof_valid", sof_valid, 1);
    check(pix_valid == 0 && line_start == 0, "R1 pixel outputs", pix_valid, 0);

    // R3: fill bank 1 completely
    blit(1, 0, FR, 64);
    // R5: handoff stalls the blitter
    send_eof(1);
    repeat (2) @(negedge clk);
    check(eof_ready == 0 && cp_ready == 0, "R5 blitter stalled", eof_ready + cp_ready, 0);

    // R7: ticks before start-of-frame do nothing
    for (int i = 0; i < 3; i++) begin
      pix_tick = 1;
      @(negedge clk);
      pix_tick = 0;
      check(pix_valid == 0, "R7 tick ignored before sof", pix_valid, 0);
      check(sof_valid == 1, "R7 sof held", sof_valid, 1);
    end

    take_frame(0, 0, "R8 old bank");
    check(front_bank == 1, "R5 swap at frame end", front_bank, 1);
    check(eof_ready == 1, "R5 blitter released", eof_ready, 1);

    take_frame(1, 1, "R3 bank1 contents");
    check(front_bank == 1, "R10 redisplay keeps bank", front_bank, 1);

    // table walk: blits into bank 0 while bank 1 is shown
    for (int e = 0; e < 5; e++) begin
      blit(0, BLITS[e][0], BLITS[e][1], BLITS[e][2]);
      if (BLITS[e][1] == 0)
        check(eof_ready == 1, "R4 zero count returns to token", eof_ready, 1);
      if (e == 1) take_frame(1, 1, "R6 no tear during blits");
    end
    check(front_bank == 1, "R6 front unchanged by blits", front_bank, 1);

    send_eof(1);
    take_frame(1, 1, "R6 frame after handoff still old bank");
    check(front_bank == 0, "R5 swap to bank0", front_bank, 0);
    check(model[0][0] == 194 && model[0][31] == 193, "R3 wrap model", model[0][0], 194);
    take_frame(0, 1, "R3 bank0 contents with wrap");
    take_frame(0, 1, "R10 redisplay bank0");
    check(front_bank == 0, "R10 no swap without handoff", front_bank, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule